// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Fabric

This block joins two or more private, direct-mapped L1 data caches to one shared bus in front of a single backing memory. Each cache takes load and store requests from its own core. A cache holds one 32-bit word per line. Stores are written through to memory.

Every cache watches each transaction on the bus. When another cache puts a write on the bus, the watching cache drops its own copy of that word. The bus acts as the point where all stores are ordered. A core that reads after a peer has written therefore misses, goes back to memory and gets the fresh value.

A core holds its request steady until the `busy` output falls for it. The access completes on the clock edge that closes a cycle in which `busy` is low. For a load, the word is valid on `core_rdata` during that cycle. The backing memory sits outside the block. It is reached through a single-cycle port, and its read data is expected in the same cycle as the address.

Top module: `snoop_coherence_fabric`

## Requirements
- R1: After reset every line in every cache is invalid. The first load of any address is a miss and places a read on the memory port.
- R2: A load miss holds `busy` high for exactly one cycle when the bus is free. That cycle carries a memory read (`mem_valid`=1, `mem_write`=0) and fills the line. In the next cycle the load completes with the memory word.
- R3: A load that hits completes in the cycle it is presented, with `busy` low and no memory read.
- R4: Every store puts a write (`mem_valid`=1, `mem_write`=1) with its address and data on the bus in the cycle it completes. Memory takes the value, and so does the storing cache's own line, so a later load from that core hits with the stored value.
- R5: A bus write from another cache clears a line only if that line holds the same full address. A later load of that address by the watching core misses and returns the written value. A line at the same index that holds a different address stays valid.
- R6: If a load would hit on a line while another cache's bus write targets the same line index in the same cycle, the snoop wins. The load sees `busy` for that cycle and is retried.
- R7: At most one cache owns the bus per cycle, and ownership rotates round-robin. When several caches request, the one granted last has the lowest priority in the next cycle.
- R8: Stores from different cores to one address are serialized by the bus. Memory ends with the value of the store granted last, and every core then reads that value.
- R9: Line index is the address modulo the number of lines, so two addresses that differ by that number evict each other.
- R10: `busy` is never high for a core that is not requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | NUM_CACHES | Per-core request strobe, held until accepted |
| core_we | input | NUM_CACHES | Per-core store select (1 = store, 0 = load) |
| core_addr | input | NUM_CACHES*16 | Per-core word address, core k in bits [16k +: 16] |
| core_wdata | input | NUM_CACHES*32 | Per-core store data, core k in bits [32k +: 32] |
| core_rdata | output | NUM_CACHES*32 | Per-core load data, valid in the completion cycle of a load |
| core_busy | output | NUM_CACHES | Per-core stall, high while the current request cannot complete |
| mem_valid | output | 1 | Bus transaction present this cycle |
| mem_write | output | 1 | Transaction is a write (1) or a read (0) |
| mem_addr | output | 16 | Word address of the transaction |
| mem_wdata | output | 32 | Write data of the transaction |
| mem_rdata | input | 32 | Memory word at `mem_addr`, same cycle |

## Verification
The bench builds the block with its defaults: two caches of eight lines each. With only two caches, every rotation of the arbiter and every write race can be set up by hand from directed stimulus. This includes a store that arrives while a peer's store is pending, and a load hit that meets a peer's store to the same line. Eight lines let a handful of small addresses cover index aliasing. They also cover the difference between an invalidate with a matching tag and one that only shares the index.

// File: rtl/snoop_coh_pkg.sv
package snoop_coh_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int SRC_W  = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [SRC_W-1:0]    src;
    } bus_txn_t;

    function automatic logic [SRC_W-1:0] src_id(input int idx);
        return SRC_W'(idx);
    endfunction

endpackage

// File: rtl/snoop_l1_cache.sv
module snoop_l1_cache
    import snoop_coh_pkg::*;
#(
    parameter int CACHE_ID  = 0,
    parameter int NUM_LINES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_busy,
    output logic              bus_req,
    output bus_txn_t          req_txn,
    input  logic              bus_grant,
    input  bus_txn_t          bus_txn,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t lines [NUM_LINES];

    logic [IDX_W-1:0] c_idx, b_idx;
    logic [TAG_W-1:0] c_tag, b_tag;
    line_t            c_line, b_line;
    logic             local_hit, foreign_write, snoop_clash, own_txn, done;

    assign c_idx  = core_addr[IDX_W-1:0];
    assign c_tag  = core_addr[ADDR_W-1:IDX_W];
    assign b_idx  = bus_txn.addr[IDX_W-1:0];
    assign b_tag  = bus_txn.addr[ADDR_W-1:IDX_W];
    assign c_line = lines[c_idx];
    assign b_line = lines[b_idx];

    assign local_hit     = c_line.valid && (c_line.tag == c_tag);
    assign own_txn       = (bus_txn.op != OP_IDLE) && (bus_txn.src == src_id(CACHE_ID));
    assign foreign_write = (bus_txn.op == OP_WRITE) && (bus_txn.src != src_id(CACHE_ID));
    // a peer store to this line slot takes precedence over a local hit
    assign snoop_clash   = foreign_write && (b_idx == c_idx);

    assign bus_req   = core_req && (core_we || !local_hit);
    assign done      = core_req && (core_we ? bus_grant : (local_hit && !snoop_clash));
    assign core_busy = core_req && !done;
    assign core_rdata = c_line.data;

    always_comb begin
        req_txn.op   = core_we ? OP_WRITE : OP_READ;
        req_txn.addr = core_addr;
        req_txn.data = core_wdata;
        req_txn.src  = src_id(CACHE_ID);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                lines[i] <= '0;
            end
        end else if (own_txn) begin
            // fill on read, write-through update on store
            lines[b_idx].valid <= 1'b1;
            lines[b_idx].tag   <= b_tag;
            lines[b_idx].data  <= (bus_txn.op == OP_READ) ? bus_rdata : bus_txn.data;
        end else if (foreign_write && b_line.valid && (b_line.tag == b_tag)) begin
            lines[b_idx].valid <= 1'b0;
        end
    end

endmodule

// File: rtl/snoop_bus_arbiter.sv
module snoop_bus_arbiter #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr, ptr_next;

    always_comb begin
        logic found;
        int   cand;
        grant    = '0;
        found    = 1'b0;
        ptr_next = ptr;
        for (int k = 0; k < N; k++) begin
            cand = int'(ptr) + k;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand]) begin
                grant[cand] = 1'b1;
                found       = 1'b1;
                ptr_next    = PTR_W'((cand + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else     ptr <= ptr_next;
    end

endmodule

// File: rtl/snoop_bus_mux.sv
module snoop_bus_mux
    import snoop_coh_pkg::*;
#(
    parameter int N = 2
) (
    input  bus_txn_t [N-1:0] txns,
    input  logic     [N-1:0] grant,
    output bus_txn_t         bus
);

    always_comb begin
        bus = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) bus = txns[k];
        end
    end

endmodule

// File: rtl/snoop_coherence_fabric.sv
module snoop_coherence_fabric
    import snoop_coh_pkg::*;
#(
    parameter int NUM_CACHES = 2,
    parameter int NUM_LINES  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CACHES-1:0]        core_req,
    input  logic [NUM_CACHES-1:0]        core_we,
    input  logic [NUM_CACHES*ADDR_W-1:0] core_addr,
    input  logic [NUM_CACHES*DATA_W-1:0] core_wdata,
    output logic [NUM_CACHES*DATA_W-1:0] core_rdata,
    output logic [NUM_CACHES-1:0]        core_busy,
    output logic                         mem_valid,
    output logic                         mem_write,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata
);

    logic     [NUM_CACHES-1:0] bus_req;
    logic     [NUM_CACHES-1:0] grant;
    bus_txn_t [NUM_CACHES-1:0] req_txn;
    bus_txn_t                  bus_txn;

    for (genvar g = 0; g < NUM_CACHES; g++) begin : g_cache
        snoop_l1_cache #(
            .CACHE_ID  (g),
            .NUM_LINES (NUM_LINES)
        ) u_cache (
            .clk        (clk),
            .rst        (rst),
            .core_req   (core_req[g]),
            .core_we    (core_we[g]),
            .core_addr  (core_addr[g*ADDR_W +: ADDR_W]),
            .core_wdata (core_wdata[g*DATA_W +: DATA_W]),
            .core_rdata (core_rdata[g*DATA_W +: DATA_W]),
            .core_busy  (core_busy[g]),
            .bus_req    (bus_req[g]),
            .req_txn    (req_txn[g]),
            .bus_grant  (grant[g]),
            .bus_txn    (bus_txn),
            .bus_rdata  (mem_rdata)
        );
    end

    snoop_bus_arbiter #(.N(NUM_CACHES)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (bus_req),
        .grant (grant)
    );

    snoop_bus_mux #(.N(NUM_CACHES)) u_mux (
        .txns  (req_txn),
        .grant (grant),
        .bus   (bus_txn)
    );

    assign mem_valid = (bus_txn.op != OP_IDLE);
    assign mem_write = (bus_txn.op == OP_WRITE);
    assign mem_addr  = bus_txn.addr;
    assign mem_wdata = bus_txn.data;

endmodule

// File: rtl/snoop_coh_checker.sv
module snoop_coh_checker
    import snoop_coh_pkg::*;
#(
    parameter int N         = 2,
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N-1:0]         core_req,
    input logic [N-1:0]         core_we,
    input logic [N*ADDR_W-1:0]  core_addr,
    input logic [N*DATA_W-1:0]  core_wdata,
    input logic [N*DATA_W-1:0]  core_rdata,
    input logic [N-1:0]         core_busy,
    input logic                 mem_valid,
    input logic                 mem_write,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [DATA_W-1:0]    mem_wdata,
    input logic [N-1:0]         bus_req,
    input logic [N-1:0]         grant
);

    localparam int IDX_W = $clog2(NUM_LINES);

    p_single_owner_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    for (genvar g = 0; g < N; g++) begin : g_chk
        logic [ADDR_W-1:0] a_g;
        logic [DATA_W-1:0] w_g, r_g;
        logic              ld_done, st_done;
        assign a_g     = core_addr[g*ADDR_W +: ADDR_W];
        assign w_g     = core_wdata[g*DATA_W +: DATA_W];
        assign r_g     = core_rdata[g*DATA_W +: DATA_W];
        assign ld_done = core_req[g] && !core_we[g] && !core_busy[g];
        assign st_done = core_req[g] && core_we[g] && !core_busy[g];

        p_busy_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
            core_busy[g] |-> core_req[g]);

        p_store_on_bus_r4: assert property (@(posedge clk) disable iff (rst)
            st_done |-> (mem_valid && mem_write && mem_addr == a_g && mem_wdata == w_g));

        p_snoop_wins_r6: assert property (@(posedge clk) disable iff (rst)
            (ld_done && mem_valid && mem_write && !grant[g])
                |-> (mem_addr[IDX_W-1:0] != a_g[IDX_W-1:0]));

        p_fresh_after_write_r5: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(mem_valid && mem_write) && ld_done && a_g == $past(mem_addr))
                |-> (r_g == $past(mem_wdata)));

        p_rotate_r7: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && grant[g] && $past(grant[g])) |-> (bus_req == (N'(1) << g)));
    end

endmodule

bind snoop_coherence_fabric snoop_coh_checker #(
    .N         (NUM_CACHES),
    .NUM_LINES (NUM_LINES)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .core_req   (core_req),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .core_rdata (core_rdata),
    .core_busy  (core_busy),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .bus_req    (bus_req),
    .grant      (grant)
);

// File: tb/snoop_coherence_fabric_test.sv
module snoop_coherence_fabric_test;

    localparam int NC = 2;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] req = '0;
    logic [NC-1:0] we  = '0;
    logic [AW-1:0] t_addr  [NC];
    logic [DW-1:0] t_wdata [NC];
    logic [NC*DW-1:0] core_rdata;
    logic [NC-1:0] core_busy;
    logic          mem_valid, mem_write;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [DW-1:0] mem [64];

    int n_chk  = 0;
    int n_fail = 0;
    int n_rd   = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    snoop_coherence_fabric #(.NUM_CACHES(NC), .NUM_LINES(8)) uut (
        .clk        (clk),
        .rst        (rst),
        .core_req   (req),
        .core_we    (we),
        .core_addr  ({t_addr[1], t_addr[0]}),
        .core_wdata ({t_wdata[1], t_wdata[0]}),
        .core_rdata (core_rdata),
        .core_busy  (core_busy),
        .mem_valid  (mem_valid),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[5:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 64; k++) mem[k] <= 32'hA000_0000 + k;
        end else if (mem_valid && mem_write) begin
            mem[mem_addr[5:0]] <= mem_wdata;
        end
        if (!rst && mem_valid && !mem_write) n_rd <= n_rd + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input int c, input logic w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd, output int stalls);
        @(negedge clk);
        req[c] = 1'b1; we[c] = w; t_addr[c] = a; t_wdata[c] = d;
        stalls = 0;
        #1;
        while (core_busy[c] && stalls < 50) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        rd = core_rdata[c*DW +: DW];
        @(negedge clk);
        req[c] = 1'b0; we[c] = 1'b0;
    endtask

    task automatic t_reset_and_miss();
        logic [31:0] rd; int st; int r0;
        @(negedge clk); #1;
        check(core_busy == '0, "R10 idle busy", 32'(core_busy), 0);
        r0 = n_rd;
        access(0, 1'b0, 16'd5, '0, rd, st);
        check(st == 1, "R1 first load misses", st, 1);
        check(rd == 32'hA000_0005, "R2 miss data", rd, 32'hA000_0005);
        check(n_rd - r0 == 1, "R2 one bus read", n_rd - r0, 1);
    endtask

    task automatic t_hit();
        logic [31:0] rd; int st; int r0;
        r0 = n_rd;
        access(0, 1'b0, 16'd5, '0, rd, st);
        check(st == 0, "R3 hit no stall", st, 0);
        check(rd == 32'hA000_0005, "R3 hit data", rd, 32'hA000_0005);
        check(n_rd == r0, "R3 no bus read", n_rd - r0, 0);
    endtask

    task automatic t_invalidate();
        logic [31:0] rd; int st;
        access(0, 1'b0, 16'd9, '0, rd, st);
        access(1, 1'b0, 16'd9, '0, rd, st);
        access(0, 1'b1, 16'd9, 32'd1, rd, st);
        check(mem[9] == 32'd1, "R4 memory written", mem[9], 1);
        access(1, 1'b0, 16'd9, '0, rd, st);
        check(st > 0, "R5 peer misses after invalidate", st, 1);
        check(rd == 32'd1, "R5 peer reads fresh value", rd, 1);
        access(0, 1'b0, 16'd9, '0, rd, st);
        check(st == 0 && rd == 32'd1, "R4 writer hits own store", rd, 1);
        // same index, different tag: no invalidate
        access(1, 1'b0, 16'd2, '0, rd, st);
        access(0, 1'b1, 16'd10, 32'h77, rd, st);
        access(1, 1'b0, 16'd2, '0, rd, st);
        check(st == 0, "R5 tag mismatch keeps line", st, 0);
        check(rd == 32'hA000_0002, "R5 kept line data", rd, 32'hA000_0002);
    endtask

    task automatic t_snoop_priority();
        logic [31:0] rd; int st;
        access(1, 1'b0, 16'd3, '0, rd, st);
        @(negedge clk);
        req = 2'b11; we = 2'b01;
        t_addr[0] = 16'd3; t_wdata[0] = 32'h55; t_addr[1] = 16'd3;
        #1;
        check(core_busy[1] == 1'b1, "R6 load hit retried on snoop", core_busy[1], 1);
        check(core_busy[0] == 1'b0, "R6 store proceeds", core_busy[0], 0);
        @(negedge clk);
        req[0] = 1'b0; we[0] = 1'b0;
        #1;
        check(core_busy[1] == 1'b1, "R6 retry misses", core_busy[1], 1);
        @(negedge clk); #1;
        check(core_busy[1] == 1'b0 && core_rdata[DW +: DW] == 32'h55, "R6 retry data",
              core_rdata[DW +: DW], 32'h55);
        @(negedge clk);
        req = '0; we = '0;
    endtask

    task automatic t_race();
        logic [31:0] rd; int st; int win; int lose;
        @(negedge clk);
        req = 2'b11; we = 2'b11;
        t_addr[0] = 16'd20; t_addr[1] = 16'd20;
        t_wdata[0] = 32'h11; t_wdata[1] = 32'h22;
        #1;
        check($countones(core_busy) == 1, "R7 one grant", 32'(core_busy), 1);
        win  = core_busy[0] ? 1 : 0;
        lose = 1 - win;
        @(negedge clk);
        t_wdata[win] = 32'h33;
        #1;
        check(core_busy[lose] == 1'b0 && core_busy[win] == 1'b1, "R7 round robin",
              32'(core_busy), 32'(1 << win));
        @(negedge clk);
        req[lose] = 1'b0; we[lose] = 1'b0;
        #1;
        check(core_busy[win] == 1'b0, "R7 repeat store served", core_busy[win], 0);
        @(negedge clk);
        req = '0; we = '0;
        check(mem[20] == 32'h33, "R8 last granted store in memory", mem[20], 32'h33);
        access(0, 1'b0, 16'd20, '0, rd, st);
        check(rd == 32'h33, "R8 core0 agrees", rd, 32'h33);
        access(1, 1'b0, 16'd20, '0, rd, st);
        check(rd == 32'h33, "R8 core1 agrees", rd, 32'h33);
    endtask

    task automatic t_alias();
        logic [31:0] rd; int st;
        access(0, 1'b0, 16'd4, '0, rd, st);
        access(0, 1'b0, 16'd12, '0, rd, st);
        check(rd == 32'hA000_000C, "R9 alias data", rd, 32'hA000_000C);
        access(0, 1'b0, 16'd4, '0, rd, st);
        check(st > 0, "R9 evicted line misses", st, 1);
        check(rd == 32'hA000_0004, "R9 refetch data", rd, 32'hA000_0004);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            t_addr[c] = '0; t_wdata[c] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_and_miss();
        t_hit();
        t_invalidate();
        t_snoop_priority();
        t_race();
        t_alias();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule